// File: doc/BRIEF.md
# 1-Wire ROM Search Engine

This block lists every 64-bit ROM identifier present on a 1-Wire bus. It runs the binary-tree search and never generates slot timing itself. Instead it asks an attached bit-slot engine for three kinds of slot: a bus reset with presence sampling, a read slot, and a write slot. One `start` pulse launches a complete search. The search is a chain of passes. Each pass resets the bus, sends the search command and then walks all 64 bit positions. Each position takes three slots: read the true bit, read the complement bit, then write the chosen direction bit.

Two signed branch markers carry over from one pass to the next: the deepest zero branch still unresolved, and the one before it. The ROM found by the last pass is also kept as the previous path. Together these let each pass settle collisions deterministically, so no device is reported twice. Every ROM the search finds is checked with the 1-Wire CRC-8 before it is presented. The engine reports a ROM as soon as its pass completes. It closes the search with a status code and the number of devices found.

Top module: `onewire_rom_search`

## Requirements
- R1: After reset `busy`, `slotReq`, `romValid` and `doneValid` are low. A `start` pulse while `busy` is high has no effect on the running search.
- R2: Every pass opens with a reset request (`slotOp` = 0). If the returned presence bit is 0, the search ends with status 2 and `devCount` 0.
- R3: After presence is seen, the engine issues eight write requests (`slotOp` = 2) carrying the command byte 0xF0, least significant bit first.
- R4: Each ROM bit position uses a read (`slotOp` = 1) of the true bit, then a read of the complement bit, then a write of the chosen direction. If both reads return 1, the search ends with status 1 and `devCount` 0.
- R5: If the two reads differ, the true bit is both recorded and written.
- R6: Both reads 0 is a collision, resolved against the branch markers, which start at -1. Below the last-zero marker the engine takes the previous path's bit, and a 0 taken there sets the previous-zero marker to that index. At the last-zero index it takes 1 and copies the previous-zero marker into the last-zero marker. Beyond that index it takes 0, moves the last-zero marker into the previous-zero marker, and sets the last-zero marker to the index.
- R7: Each device on the bus is reported exactly once. Devices come out in ascending order, comparing ROMs bit by bit from bit 0, with 0 ranked before 1.
- R8: The CRC-8 (x^8+x^5+x^4+1, LSB first, initial value 0) over all 64 found bits must be zero, which means byte 7 matches bytes 0 to 6. Otherwise the search ends with status 3, `devCount` 0, and no `romValid` for that pass.
- R9: A pass whose ROM passes the CRC check gives a one-cycle `romValid` with `romData` bit i equal to ROM bit i. `devCount` rises by one on the following cycle.
- R10: A pass that took no new 0 branch ends the search with status 0, and `devCount` equals the number of devices found.
- R11: If the count reaches `MAX_DEV` while a pass still took a new 0 branch, the search ends with status 4 and `devCount` equal to `MAX_DEV`.
- R12: `slotReq` is a single-cycle pulse raised only while `busy`. The engine waits for `slotDone` before issuing the next request. `doneValid` is a one-cycle pulse with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches a full search while idle |
| slotDone | input | 1 | Slot engine finished the requested slot |
| slotRdBit | input | 1 | Sampled bus bit or presence flag, valid with `slotDone` |
| slotReq | output | 1 | One-cycle slot request |
| slotOp | output | 2 | Slot kind: 0 reset, 1 read, 2 write |
| slotWrBit | output | 1 | Bit to drive in a write slot |
| busy | output | 1 | Search in progress |
| romValid | output | 1 | `romData` holds a freshly found, CRC-checked ROM |
| romData | output | 64 | Found ROM, bit 0 first on the bus |
| doneValid | output | 1 | Search finished; status and count are valid |
| doneStatus | output | 3 | 0 all found, 1 no response, 2 no presence, 3 CRC error, 4 overflow |
| devCount | output | clog2(MAX_DEV+1) | Devices found so far; 0 after any error end |

## Verification
A behavioural bus model answers each slot as the wired AND of the devices still taking part. The bench sweeps one to four devices with generated ROMs and varies the slot latency. Each sweep checks the enumeration order against a sort computed in the bench, which separates correct collision resolution from a wrong branch choice or a marker mistake. A hand-built set differs at bit 3 and bit 40 to force a shallow and a deep collision in the same search, with a device count equal to `MAX_DEV`. A fifth device then pushes the same search into overflow. Error patterns are tested one at a time: no presence, presence with no responder, and a device with a corrupted CRC byte. Each must give its own status code with a zero count. A stray `start` during a search must not change the result or the number of resets.

// File: rtl/onewire_search_pkg.sv
package onewire_search_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } slot_op_t;

  typedef enum logic [2:0] {
    ST_ALL_FOUND = 3'd0,
    ST_NO_RESP   = 3'd1,
    ST_NO_PRES   = 3'd2,
    ST_CRC_BAD   = 3'd3,
    ST_OVERFLOW  = 3'd4
  } search_status_t;

  localparam logic [7:0] SEARCH_CMD = 8'hF0;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;     // new search: markers, path, count
    logic clrPass;    // new pass: bit index, crc, rom
    logic capTrue;    // latch true-bit read
    logic decide;     // complement read done: pick direction
    logic advance;    // next bit position
    logic bump;       // pass succeeded: count and path
    logic zeroCount;  // error end
  } dp_ctl_t;

endpackage

// File: rtl/ows_datapath.sv
module ows_datapath
  import onewire_search_pkg::*;
#(
  parameter int ROM_BITS = 64,
  parameter int MAX_DEV  = 8,
  parameter int IDX_W    = $clog2(ROM_BITS),
  parameter int CNT_W    = $clog2(MAX_DEV + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctl_t             ctl,
  input  logic                slotRdBit,
  output logic                dirBit,
  output logic                bothOnes,
  output logic                lastBit,
  output logic                crcOk,
  output logic                tookZero,
  output logic                nearFull,
  output logic [ROM_BITS-1:0] romData,
  output logic [CNT_W-1:0]    count
);

  logic [IDX_W-1:0]    bitIdx;
  logic                trueBit;
  logic [ROM_BITS-1:0] romReg;
  logic [ROM_BITS-1:0] prevPath;
  logic signed [IDX_W:0] lastZero;
  logic signed [IDX_W:0] prevZero;
  logic [7:0]          crc;

  logic                nxtDir;
  logic                zeroTaken;
  logic signed [IDX_W:0] nxtLast;
  logic signed [IDX_W:0] nxtPrev;
  logic signed [IDX_W:0] idxS;

  function automatic logic [7:0] crcStep(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[7:1]} ^ (fb ? 8'h8C : 8'h00);
  endfunction

  // direction choice for the current bit position
  always_comb begin
    idxS      = $signed({1'b0, bitIdx});
    nxtDir    = 1'b0;
    nxtLast   = lastZero;
    nxtPrev   = prevZero;
    zeroTaken = 1'b0;
    if (trueBit != slotRdBit) begin
      nxtDir = trueBit;
    end else if (idxS < lastZero) begin
      nxtDir = prevPath[bitIdx];
      if (!nxtDir) begin
        nxtPrev   = idxS;
        zeroTaken = 1'b1;
      end
    end else if (idxS == lastZero) begin
      nxtDir  = 1'b1;
      nxtLast = prevZero;
    end else begin
      nxtDir    = 1'b0;
      nxtPrev   = lastZero;
      nxtLast   = idxS;
      zeroTaken = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx   <= '0;
      trueBit  <= 1'b0;
      romReg   <= '0;
      prevPath <= '0;
      lastZero <= '1;
      prevZero <= '1;
      crc      <= '0;
      dirBit   <= 1'b0;
      tookZero <= 1'b0;
      count    <= '0;
    end else begin
      if (ctl.clrAll) begin
        lastZero <= '1;
        prevZero <= '1;
        prevPath <= '0;
        count    <= '0;
      end
      if (ctl.clrPass) begin
        bitIdx   <= '0;
        crc      <= '0;
        romReg   <= '0;
        tookZero <= 1'b0;
      end
      if (ctl.capTrue) trueBit <= slotRdBit;
      if (ctl.decide) begin
        dirBit         <= nxtDir;
        romReg[bitIdx] <= nxtDir;
        crc            <= crcStep(crc, nxtDir);
        lastZero       <= nxtLast;
        prevZero       <= nxtPrev;
        if (zeroTaken) tookZero <= 1'b1;
      end
      if (ctl.advance) bitIdx <= bitIdx + 1'b1;
      if (ctl.bump) begin
        count    <= count + 1'b1;
        prevPath <= romReg;
      end
      if (ctl.zeroCount) count <= '0;
    end
  end

  assign bothOnes = trueBit & slotRdBit;
  assign lastBit  = (bitIdx == IDX_W'(ROM_BITS - 1));
  assign crcOk    = (crc == 8'h00);
  assign nearFull = (count == CNT_W'(MAX_DEV - 1));
  assign romData  = romReg;

endmodule

// File: rtl/ows_ctrl.sv
module ows_ctrl
  import onewire_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       slotDone,
  input  logic       slotRdBit,
  input  logic       dirBit,
  input  logic       bothOnes,
  input  logic       lastBit,
  input  logic       crcOk,
  input  logic       tookZero,
  input  logic       nearFull,
  output dp_ctl_t    ctl,
  output logic       slotReq,
  output logic [1:0] slotOp,
  output logic       slotWrBit,
  output logic       busy,
  output logic       romValid,
  output logic       doneValid,
  output logic [2:0] doneStatus
);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_REQ, S_RST_WAIT, S_CMD_REQ, S_CMD_WAIT,
    S_TRUE_REQ, S_TRUE_WAIT, S_COMP_REQ, S_COMP_WAIT,
    S_DIR_REQ, S_DIR_WAIT, S_CHECK
  } state_t;

  state_t         state, nextState;
  logic [2:0]     cmdIdx;
  logic           finish;
  search_status_t finStat;

  always_comb begin
    ctl       = '0;
    slotReq   = 1'b0;
    slotOp    = OP_READ;
    slotWrBit = 1'b1;
    romValid  = 1'b0;
    finish    = 1'b0;
    finStat   = ST_ALL_FOUND;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        ctl.clrAll  = 1'b1;
        ctl.clrPass = 1'b1;
        nextState   = S_RST_REQ;
      end
      S_RST_REQ: begin
        slotReq   = 1'b1;
        slotOp    = OP_RESET;
        nextState = S_RST_WAIT;
      end
      S_RST_WAIT: if (slotDone) begin
        if (slotRdBit) nextState = S_CMD_REQ;
        else begin
          finish  = 1'b1;
          finStat = ST_NO_PRES;
        end
      end
      S_CMD_REQ: begin
        slotReq   = 1'b1;
        slotOp    = OP_WRITE;
        slotWrBit = SEARCH_CMD[cmdIdx];
        nextState = S_CMD_WAIT;
      end
      S_CMD_WAIT: if (slotDone)
        nextState = (cmdIdx == 3'd7) ? S_TRUE_REQ : S_CMD_REQ;
      S_TRUE_REQ: begin
        slotReq   = 1'b1;
        nextState = S_TRUE_WAIT;
      end
      S_TRUE_WAIT: if (slotDone) begin
        ctl.capTrue = 1'b1;
        nextState   = S_COMP_REQ;
      end
      S_COMP_REQ: begin
        slotReq   = 1'b1;
        nextState = S_COMP_WAIT;
      end
      S_COMP_WAIT: if (slotDone) begin
        if (bothOnes) begin
          finish  = 1'b1;
          finStat = ST_NO_RESP;
        end else begin
          ctl.decide = 1'b1;
          nextState  = S_DIR_REQ;
        end
      end
      S_DIR_REQ: begin
        slotReq   = 1'b1;
        slotOp    = OP_WRITE;
        slotWrBit = dirBit;
        nextState = S_DIR_WAIT;
      end
      S_DIR_WAIT: if (slotDone) begin
        if (lastBit) nextState = S_CHECK;
        else begin
          ctl.advance = 1'b1;
          nextState   = S_TRUE_REQ;
        end
      end
      S_CHECK: begin
        if (!crcOk) begin
          finish  = 1'b1;
          finStat = ST_CRC_BAD;
        end else begin
          romValid = 1'b1;
          ctl.bump = 1'b1;
          if (!tookZero) begin
            finish  = 1'b1;
            finStat = ST_ALL_FOUND;
          end else if (nearFull) begin
            finish  = 1'b1;
            finStat = ST_OVERFLOW;
          end else begin
            ctl.clrPass = 1'b1;
            nextState   = S_RST_REQ;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
    if (finish) begin
      nextState     = S_IDLE;
      ctl.zeroCount = (finStat != ST_ALL_FOUND) && (finStat != ST_OVERFLOW);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cmdIdx     <= '0;
      doneValid  <= 1'b0;
      doneStatus <= '0;
    end else begin
      state     <= nextState;
      doneValid <= finish;
      if (finish) doneStatus <= finStat;
      if (state == S_RST_WAIT) cmdIdx <= '0;
      else if (state == S_CMD_WAIT && slotDone) cmdIdx <= cmdIdx + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/onewire_rom_search.sv
module onewire_rom_search
  import onewire_search_pkg::*;
#(
  parameter int  ROM_BYTES = 8,
  parameter int  MAX_DEV   = 8,
  localparam int ROM_BITS  = ROM_BYTES * 8,
  localparam int IDX_W     = $clog2(ROM_BITS),
  localparam int CNT_W     = $clog2(MAX_DEV + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                slotDone,
  input  logic                slotRdBit,
  output logic                slotReq,
  output logic [1:0]          slotOp,
  output logic                slotWrBit,
  output logic                busy,
  output logic                romValid,
  output logic [ROM_BITS-1:0] romData,
  output logic                doneValid,
  output logic [2:0]          doneStatus,
  output logic [CNT_W-1:0]    devCount
);

  dp_ctl_t ctl;
  logic    dirBit, bothOnes, lastBit, crcOk, tookZero, nearFull;

  ows_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .slotDone  (slotDone),
    .slotRdBit (slotRdBit),
    .dirBit    (dirBit),
    .bothOnes  (bothOnes),
    .lastBit   (lastBit),
    .crcOk     (crcOk),
    .tookZero  (tookZero),
    .nearFull  (nearFull),
    .ctl       (ctl),
    .slotReq   (slotReq),
    .slotOp    (slotOp),
    .slotWrBit (slotWrBit),
    .busy      (busy),
    .romValid  (romValid),
    .doneValid (doneValid),
    .doneStatus(doneStatus)
  );

  ows_datapath #(
    .ROM_BITS(ROM_BITS),
    .MAX_DEV (MAX_DEV),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .slotRdBit(slotRdBit),
    .dirBit   (dirBit),
    .bothOnes (bothOnes),
    .lastBit  (lastBit),
    .crcOk    (crcOk),
    .tookZero (tookZero),
    .nearFull (nearFull),
    .romData  (romData),
    .count    (devCount)
  );

endmodule

// File: rtl/onewire_rom_search_chk.sv
module onewire_rom_search_chk #(
  parameter int MAX_DEV = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             slotReq,
  input logic             busy,
  input logic             romValid,
  input logic             doneValid,
  input logic [2:0]       doneStatus,
  input logic [CNT_W-1:0] devCount
);

  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |=> !slotReq);

  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |-> busy);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busy);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    romValid |=> devCount == CNT_W'($past(devCount) + 1'b1));

  p_err_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus != 3'd0 && doneStatus != 3'd4) |-> devCount == '0);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus == 3'd4) |-> devCount == CNT_W'(MAX_DEV));

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    devCount <= CNT_W'(MAX_DEV));

endmodule

bind onewire_rom_search onewire_rom_search_chk #(
  .MAX_DEV(MAX_DEV),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .slotReq   (slotReq),
  .busy      (busy),
  .romValid  (romValid),
  .doneValid (doneValid),
  .doneStatus(doneStatus),
  .devCount  (devCount)
);

// File: tb/onewire_rom_search_test.sv
`timescale 1ns/1ps
module onewire_rom_search_test;

  localparam int MAXD = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        slotDone = 1'b0;
  logic        slotRdBit = 1'b0;
  logic        slotReq, slotWrBit, busy, romValid, doneValid;
  logic [1:0]  slotOp;
  logic [63:0] romData;
  logic [2:0]  doneStatus;
  logic [2:0]  devCount;

  always #2 clk = ~clk;

  onewire_rom_search #(.ROM_BYTES(8), .MAX_DEV(MAXD)) uut (
    .clk(clk), .rstN(rstN), .start(start), .slotDone(slotDone),
    .slotRdBit(slotRdBit), .slotReq(slotReq), .slotOp(slotOp),
    .slotWrBit(slotWrBit), .busy(busy), .romValid(romValid),
    .romData(romData), .doneValid(doneValid), .doneStatus(doneStatus),
    .devCount(devCount)
  );

  int checks = 0;
  int errors = 0;

  // bus model state
  logic [63:0] devRom [8];
  bit          devAct [8];
  int          devNum = 0;
  bit          presenceOn = 1'b1;
  int          lat = 1;
  int          cmdCnt = 0;
  logic [7:0]  cmdSeen = '0;
  int          step = 0;
  int          bitPos = 0;
  int          resetsSeen = 0;
  int          cmdBad = 0;
  int          protoBad = 0;

  // observed results
  logic [63:0] found [8];
  int          foundCnt = 0;
  bit          gotDone = 1'b0;
  logic [2:0]  gotStat = '0;
  logic [2:0]  gotCount = '0;
  bit          prevReq = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crcOf(input logic [63:0] v, input int nbits);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < nbits; i++)
      c = (c[0] ^ v[i]) ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    return c;
  endfunction

  function automatic logic [63:0] withCrc(input logic [55:0] body);
    return {crcOf({8'h00, body}, 56), body};
  endfunction

  function automatic logic [63:0] genRom(input int seed);
    logic [63:0] x;
    x = 64'(seed) * 64'h5851F42D4C957F2D + 64'h14057B7EF767814F;
    x = x * 64'h5851F42D4C957F2D + 64'h1405;
    return withCrc(x[59:4]);
  endfunction

  function automatic logic [63:0] rev(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = v[63-i];
    return r;
  endfunction

  // slot engine and bus model
  initial forever begin
    logic rd;
    @(negedge clk);
    slotDone = 1'b0;
    if (slotReq) begin
      rd = 1'b1;
      case (slotOp)
        2'd0: begin
          rd = presenceOn;
          for (int i = 0; i < 8; i++) devAct[i] = (i < devNum);
          cmdCnt = 0; step = 0; bitPos = 0; resetsSeen++;
        end
        2'd1: begin
          if (cmdCnt < 8 || step == 2) protoBad++;
          for (int i = 0; i < devNum; i++)
            if (devAct[i]) rd = rd & (step == 0 ? devRom[i][bitPos] : ~devRom[i][bitPos]);
          step++;
        end
        default: begin
          if (cmdCnt < 8) begin
            cmdSeen[cmdCnt] = slotWrBit;
            cmdCnt++;
            if (cmdCnt == 8 && cmdSeen != 8'hF0) cmdBad++;
          end else begin
            if (step != 2) protoBad++;
            for (int i = 0; i < devNum; i++)
              if (devAct[i] && devRom[i][bitPos] != slotWrBit) devAct[i] = 1'b0;
            bitPos++; step = 0;
          end
        end
      endcase
      repeat (lat) @(negedge clk);
      slotDone = 1'b1;
      slotRdBit = rd;
    end
  end

  // output monitor
  initial forever begin
    @(negedge clk);
    if (slotReq && (prevReq || !busy)) protoBad++;
    prevReq = slotReq;
    if (romValid && foundCnt < 8) begin
      found[foundCnt] = romData;
      foundCnt++;
    end
    if (doneValid) begin
      gotDone = 1'b1;
      gotStat = doneStatus;
      gotCount = devCount;
    end
  end

  task automatic runSearch(input bit extraStart);
    foundCnt = 0; gotDone = 1'b0; resetsSeen = 0; cmdBad = 0; protoBad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extraStart) begin
      repeat (150) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!gotDone) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // run with devRom[0..n-1] loaded; expects success or overflow
  task automatic runGood(input int n, input bit extraStart, input string tag);
    logic [63:0] srt [8];
    logic [63:0] t;
    int expN;
    for (int i = 0; i < n; i++) srt[i] = devRom[i];
    for (int i = 0; i < n; i++)
      for (int j = 0; j + 1 < n - i; j++)
        if (rev(srt[j]) > rev(srt[j+1])) begin
          t = srt[j]; srt[j] = srt[j+1]; srt[j+1] = t;
        end
    devNum = n; presenceOn = 1'b1;
    runSearch(extraStart);
    expN = (n > MAXD) ? MAXD : n;
    check(gotStat == ((n > MAXD) ? 3'd4 : 3'd0), {tag, " R10 R11 status"}, 64'(gotStat),
          (n > MAXD) ? 64'd4 : 64'd0);
    check(gotCount == 3'(expN), {tag, " R10 count"}, 64'(gotCount), 64'(expN));
    check(foundCnt == expN, {tag, " R9 romValid strobes"}, 64'(foundCnt), 64'(expN));
    for (int i = 0; i < expN && i < foundCnt; i++)
      check(found[i] == srt[i], {tag, " R7 R6 R5 order"}, found[i], srt[i]);
    check(resetsSeen == expN, {tag, " R2 resets per pass"}, 64'(resetsSeen), 64'(expN));
    check(cmdBad == 0, {tag, " R3 command byte"}, 64'(cmdBad), 64'd0);
    check(protoBad == 0, {tag, " R4 R12 slot order"}, 64'(protoBad), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [55:0] base;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!busy && !slotReq && !romValid && !doneValid, "R1 reset outputs",
          {60'd0, busy, slotReq, romValid, doneValid}, 64'd0);
    check(devCount == 3'd0, "R1 reset count", 64'(devCount), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // sweep: 1..4 devices, generated ROMs, varied latency
    for (int n = 1; n <= MAXD; n++)
      for (int s = 0; s < 5; s++) begin
        lat = 1 + ((n + s) % 2);
        for (int i = 0; i < n; i++) devRom[i] = genRom(n * 101 + s * 13 + i);
        runGood(n, 1'b0, "sweep");
      end

    // R6: shallow and deep collision, count equal to MAX_DEV
    lat = 1;
    base = 56'h3C_5A96_0F17_2B44;
    base[3] = 1'b0; base[40] = 1'b0;
    devRom[0] = withCrc(base);
    devRom[1] = withCrc(base | (56'd1 << 3));
    devRom[2] = withCrc(base | (56'd1 << 40));
    devRom[3] = withCrc(base | (56'd1 << 3) | (56'd1 << 40));
    runGood(4, 1'b0, "R6 deep");

    // R11 overflow with a fifth device
    devRom[4] = genRom(777);
    runGood(5, 1'b0, "R11 overflow");

    // R1 start while busy ignored
    for (int i = 0; i < 3; i++) devRom[i] = genRom(900 + i);
    runGood(3, 1'b1, "R1 restart ignored");

    // R2 no presence
    devNum = 1; devRom[0] = genRom(5); presenceOn = 1'b0;
    runSearch(1'b0);
    check(gotStat == 3'd2, "R2 no presence status", 64'(gotStat), 64'd2);
    check(gotCount == 3'd0 && foundCnt == 0, "R2 no presence count", 64'(gotCount), 64'd0);
    check(resetsSeen == 1 && cmdCnt == 0, "R2 nothing after reset", 64'(cmdCnt), 64'd0);

    // R4 presence but nobody answers
    devNum = 0; presenceOn = 1'b1;
    runSearch(1'b0);
    check(gotStat == 3'd1, "R4 no response status", 64'(gotStat), 64'd1);
    check(gotCount == 3'd0 && foundCnt == 0, "R4 no response count", 64'(gotCount), 64'd0);

    // R8 bad CRC byte
    devRom[0] = genRom(42);
    devRom[0][63:56] = ~devRom[0][63:56];
    devNum = 1;
    runSearch(1'b0);
    check(gotStat == 3'd3, "R8 crc status", 64'(gotStat), 64'd3);
    check(gotCount == 3'd0, "R8 crc count", 64'(gotCount), 64'd0);
    check(foundCnt == 0, "R8 no romValid", 64'(foundCnt), 64'd0);

    // recovery after errors
    devRom[0] = genRom(43); devRom[1] = genRom(44);
    runGood(2, 1'b0, "R8 recovery");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule